// File: doc/BRIEF.md
# Asynchronous Host Bus to Avalon-MM Master Bridge

This block lets an external processor, which sees the FPGA as a plain 16-bit memory on an asynchronous, non-multiplexed bus, start single transfers on an on-chip Avalon memory-mapped fabric. The host drives an active-low chip select, write enable and output enable, together with an address and write data. The bridge synchronises the three strobes into the fabric clock. It then runs one Avalon read or write transfer with active-high controls and hands any read data back on a registered output.

The host strobes never reach the fabric directly. The fabric may hold waitrequest high while idle, drop it only once a transfer is served, and raise it again one clock after the master releases read or write. A small state machine therefore owns the Avalon controls. It raises one strobe for each host access and holds it until waitrequest is sampled low. It then parks until the host lets go of chip select, so that a long host strobe never becomes a second transfer.

Top module: `hbus_avm_bridge`

## Requirements
- R1: While rst is high and in the first cycle after it, avm_read and avm_write are low and host_rdata is zero.
- R2: With host_cs_n low, host_we_n low starts a write and host_oe_n low starts a read. When both are low the write wins.
- R3: From the cycle a transfer starts until it completes, avm_address and avm_writedata stay stable, carrying the host address and data captured at the start.
- R4: The bridge keeps avm_read or avm_write high while avm_waitrequest is high, including when waitrequest is already high as the transfer begins.
- R5: In the cycle after avm_waitrequest is sampled low with a strobe high, both avm_read and avm_write are low.
- R6: One host access, however long its strobes are held, produces exactly one Avalon transfer. No new transfer starts until host_cs_n has been seen high.
- R7: avm_readdata is captured in the cycle where avm_read is high and avm_waitrequest is low. host_rdata then holds that value through later writes and idle time, until the next read completes.
- R8: While host_cs_n is high, low levels on host_we_n or host_oe_n start no transfer and leave host_rdata unchanged.
- R9: avm_read and avm_write are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_we_n | input | 1 | Host write enable, active low, asynchronous |
| host_oe_n | input | 1 | Host output enable, active low, asynchronous |
| host_addr | input | ADDR_W | Host address, stable while chip select is low |
| host_wdata | input | DATA_W | Host write data, stable while write enable is low |
| host_rdata | output | DATA_W | Registered data of the last completed read |
| avm_address | output | ADDR_W | Avalon address |
| avm_read | output | 1 | Avalon read request, active high |
| avm_write | output | 1 | Avalon write request, active high |
| avm_writedata | output | DATA_W | Avalon write data |
| avm_readdata | input | DATA_W | Avalon read data |
| avm_waitrequest | input | 1 | Avalon wait request, active high |

## Verification
The assertions assume the host keeps address and write data stable while its strobes are low. They also assume the host releases chip select between accesses, and that the fabric keeps waitrequest high at idle and raises it again one clock after read or write falls. The bench slave model follows that waitrequest pattern, with a random serve delay from zero to several cycles. It drives random garbage on readdata except in the serving cycle, so a capture taken in the wrong cycle shows up. The host tasks hold address and data across the whole strobe and sometimes keep the strobe low for many cycles after completion. They also wait a random idle time before the next access.

// File: rtl/hbus_avm_pkg.sv
package hbus_avm_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_BUSY = 2'd1,
    XS_PARK = 2'd2
  } xfer_state_t;

  localparam int unsigned STROBE_N = 3;
  localparam int unsigned IDX_CS   = 0;
  localparam int unsigned IDX_WE   = 1;
  localparam int unsigned IDX_OE   = 2;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= RST_VAL;
          else     stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= RST_VAL;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/hbus_avm_ctrl.sv
module hbus_avm_ctrl
  import hbus_avm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] avm_readdata,
  input  logic              avm_waitrequest,
  output logic [ADDR_W-1:0] avm_address,
  output logic              avm_read,
  output logic              avm_write,
  output logic [DATA_W-1:0] avm_writedata,
  output logic [DATA_W-1:0] rdata_q
);
  xfer_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= XS_IDLE;
      avm_address   <= '0;
      avm_writedata <= '0;
      avm_read      <= 1'b0;
      avm_write     <= 1'b0;
      rdata_q       <= '0;
    end else begin
      case (state_q)
        XS_IDLE: begin
          if (sel && (wr_req || rd_req)) begin
            avm_address   <= host_addr;
            avm_writedata <= host_wdata;
            avm_write     <= wr_req;
            avm_read      <= !wr_req;
            state_q       <= XS_BUSY;
          end
        end
        XS_BUSY: begin
          if (!avm_waitrequest) begin
            if (avm_read) rdata_q <= avm_readdata;
            avm_read  <= 1'b0;
            avm_write <= 1'b0;
            state_q   <= XS_PARK;
          end
        end
        XS_PARK: begin
          if (!sel) state_q <= XS_IDLE;
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hbus_avm_bridge.sv
module hbus_avm_bridge
  import hbus_avm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs_n,
  input  logic              host_we_n,
  input  logic              host_oe_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] avm_address,
  output logic              avm_read,
  output logic              avm_write,
  output logic [DATA_W-1:0] avm_writedata,
  input  logic [DATA_W-1:0] avm_readdata,
  input  logic              avm_waitrequest
);
  logic [STROBE_N-1:0] strobe_raw_n;
  logic [STROBE_N-1:0] strobe_sync_n;

  assign strobe_raw_n[IDX_CS] = host_cs_n;
  assign strobe_raw_n[IDX_WE] = host_we_n;
  assign strobe_raw_n[IDX_OE] = host_oe_n;

  hbus_sync #(
    .WIDTH  (STROBE_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL({STROBE_N{1'b1}})
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(strobe_raw_n),
    .q_sync (strobe_sync_n)
  );

  hbus_avm_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .sel            (!strobe_sync_n[IDX_CS]),
    .wr_req         (!strobe_sync_n[IDX_WE]),
    .rd_req         (!strobe_sync_n[IDX_OE]),
    .host_addr      (host_addr),
    .host_wdata     (host_wdata),
    .avm_readdata   (avm_readdata),
    .avm_waitrequest(avm_waitrequest),
    .avm_address    (avm_address),
    .avm_read       (avm_read),
    .avm_write      (avm_write),
    .avm_writedata  (avm_writedata),
    .rdata_q        (host_rdata)
  );
endmodule

// File: rtl/hbus_avm_bridge_chk.sv
module hbus_avm_bridge_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] host_rdata,
  input logic [ADDR_W-1:0] avm_address,
  input logic              avm_read,
  input logic              avm_write,
  input logic [DATA_W-1:0] avm_writedata,
  input logic [DATA_W-1:0] avm_readdata,
  input logic              avm_waitrequest
);
  logic active;
  assign active = avm_read || avm_write;

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (avm_read && avm_waitrequest) |=> avm_read);

  p_hold_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (avm_write && avm_waitrequest) |=> avm_write);

  p_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (active && avm_waitrequest) |=> ($stable(avm_address) && $stable(avm_writedata)));

  p_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (active && !avm_waitrequest) |=> !active);

  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (avm_read && !avm_waitrequest) |=> (host_rdata == $past(avm_readdata)));

  p_keep_r7: assert property (@(posedge clk) disable iff (rst)
    !(avm_read && !avm_waitrequest) |=> $stable(host_rdata));

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(avm_read && avm_write));
endmodule

bind hbus_avm_bridge hbus_avm_bridge_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .host_rdata     (host_rdata),
  .avm_address    (avm_address),
  .avm_read       (avm_read),
  .avm_write      (avm_write),
  .avm_writedata  (avm_writedata),
  .avm_readdata   (avm_readdata),
  .avm_waitrequest(avm_waitrequest)
);

// File: tb/hbus_avm_bridge_tb.sv
module hbus_avm_bridge_tb;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG_CYCLES = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_cs_n = 1'b1;
  logic              host_we_n = 1'b1;
  logic              host_oe_n = 1'b1;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic [ADDR_W-1:0] avm_address;
  logic              avm_read;
  logic              avm_write;
  logic [DATA_W-1:0] avm_writedata;
  logic [DATA_W-1:0] avm_readdata;
  logic              avm_waitrequest;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbus_avm_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst),
    .host_cs_n(host_cs_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .avm_address(avm_address), .avm_read(avm_read), .avm_write(avm_write),
    .avm_writedata(avm_writedata), .avm_readdata(avm_readdata),
    .avm_waitrequest(avm_waitrequest)
  );

  // Slave model: waitrequest high at idle, one clock after a strobe falls it rises again
  logic [DATA_W-1:0] slv_mem [1 << ADDR_W];
  logic              slv_wait;
  logic [DATA_W-1:0] slv_rdata;
  int unsigned       slv_cnt;
  int unsigned       slv_delay = 0;

  assign avm_waitrequest = slv_wait;
  assign avm_readdata    = slv_rdata;

  always @(posedge clk) begin
    if (rst) begin
      slv_wait  <= 1'b1;
      slv_cnt   <= 0;
      slv_rdata <= '0;
      for (int i = 0; i < (1 << ADDR_W); i++) slv_mem[i] <= '0;
    end else begin
      slv_rdata <= DATA_W'($urandom);
      if (avm_read || avm_write) begin
        if (slv_wait) begin
          if (slv_cnt == 0) begin
            slv_wait <= 1'b0;
            if (avm_read) slv_rdata <= slv_mem[avm_address];
            else          slv_mem[avm_address] <= avm_writedata;
          end else begin
            slv_cnt <= slv_cnt - 1;
          end
        end
      end else begin
        slv_cnt <= slv_delay;
        if (!slv_wait) slv_wait <= 1'b1;
      end
    end
  end

  // Transfer monitor, sampled at the falling edge
  int unsigned       n_xfer = 0;
  bit                last_wr;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_wdata;

  always @(negedge clk) begin
    if (!rst && (avm_read || avm_write) && !avm_waitrequest) begin
      n_xfer     <= n_xfer + 1;
      last_wr    <= avm_write;
      last_addr  <= avm_address;
      last_wdata <= avm_writedata;
    end
  end

  logic [DATA_W-1:0] shadow [1 << ADDR_W];
  logic [DATA_W-1:0] exp_rdata = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] model_read(input logic [ADDR_W-1:0] a);
    return shadow[a];
  endfunction

  // One host access. kind: 0 write, 1 read, 2 both enables low (write wins)
  task automatic host_access(input int kind, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, input int hold);
    int unsigned start_n;
    bit          is_wr;
    is_wr = (kind != 1);
    start_n = n_xfer;
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_cs_n  = 1'b0;
    host_we_n  = (kind == 1);
    host_oe_n  = (kind == 0);
    for (int i = 0; i < 200 && n_xfer == start_n; i++) @(negedge clk);
    @(negedge clk);
    check(!avm_read && !avm_write, "R5", "strobe low after serve",
          {30'd0, avm_read, avm_write}, 32'd0);
    for (int i = 0; i < hold; i++) @(negedge clk);
    check(n_xfer == start_n + 1, "R6", "one transfer per access", n_xfer - start_n, 1);
    check(last_wr == is_wr, "R2", "transfer kind", {31'd0, last_wr}, {31'd0, is_wr});
    check(last_addr == a, "R3", "address", last_addr, a);
    if (is_wr) begin
      check(last_wdata == d, "R3", "writedata", last_wdata, d);
      shadow[a] = d;
    end else begin
      exp_rdata = model_read(a);
    end
    check(host_rdata == exp_rdata, "R7", "host_rdata", host_rdata, exp_rdata);
    host_cs_n = 1'b1;
    host_we_n = 1'b1;
    host_oe_n = 1'b1;
    host_addr  = ADDR_W'($urandom);
    host_wdata = DATA_W'($urandom);
    for (int i = 0; i < 4; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < (1 << ADDR_W); i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    check(!avm_read && !avm_write, "R1", "strobes in reset", {30'd0, avm_read, avm_write}, 0);
    check(host_rdata == '0, "R1", "host_rdata in reset", host_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!avm_read && !avm_write && host_rdata == '0, "R1", "after reset",
          {avm_read, avm_write, 14'd0, host_rdata}, 0);

    // Directed: slow and zero-delay serve, with a waitrequest high at start (R4)
    slv_delay = 5;
    host_access(0, 8'h12, 16'hBEEF, 0);
    slv_delay = 0;
    host_access(1, 8'h12, 16'h0000, 0);
    slv_delay = 3;
    host_access(2, 8'h34, 16'hA5A5, 2);
    host_access(1, 8'h34, 16'h0000, 20);   // long strobe: R6
    host_access(0, 8'h00, 16'h1111, 0);    // write keeps host_rdata: R7
    check(host_rdata == 16'hA5A5, "R7", "rdata kept over write", host_rdata, 16'hA5A5);

    // R8: enables low without chip select
    begin
      int unsigned n0;
      n0 = n_xfer;
      @(negedge clk);
      host_we_n = 1'b0;
      host_oe_n = 1'b0;
      for (int i = 0; i < 12; i++) @(negedge clk);
      check(n_xfer == n0 && !avm_read && !avm_write, "R8", "no transfer without select",
            n_xfer - n0, 0);
      check(host_rdata == 16'hA5A5, "R8", "rdata unchanged", host_rdata, 16'hA5A5);
      host_we_n = 1'b1;
      host_oe_n = 1'b1;
      for (int i = 0; i < 4; i++) @(negedge clk);
    end

    // Random mix
    for (int n = 0; n < 60; n++) begin
      slv_delay = $urandom_range(0, 6);
      host_access($urandom_range(0, 2), ADDR_W'($urandom_range(0, 15)),
                  DATA_W'($urandom), $urandom_range(0, 8));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // R9 observed at the ports each cycle
  always @(negedge clk) begin
    if (!rst && !done && avm_read && avm_write)
      check(1'b0, "R9", "read and write together", 1, 0);
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule